// File: doc/BRIEF.md
# Discrete-Input Sensor SPI Register Slave

This block is the device side of a serial register port for a bank of discrete-input sense channels. A host frames each transfer with an active-low select and clocks bytes in SPI mode 0. The first byte is a command: its top bit picks the direction and its low seven bits give a starting register address. The bytes that follow are either written into consecutive registers or returned from them, most significant byte first.

The register set covers a control word (test enable and soft reset), a per-bank sensing-mode word, a test data byte, two 16-bit threshold/hysteresis words (one per sensing mode) and the live channel states. The channel states can be read one bank per byte or all together in a four-byte burst. The comparators themselves are outside the block: their results arrive as a parallel channel word. The stored configuration is driven out on ports for the analog side. The serial inputs are resynchronised into the system clock, so the serial clock must run several times slower than the system clock.

Top module: `dsi_spi_slave`

## Requirements
- R1: Transfers are framed by cs_n low; mosi is taken on each rising sclk edge MSB first and miso changes after falling edges; miso is 0 while cs_n is high, and an incomplete byte before cs_n rises has no effect.
- R2: Bits 6:0 of the first byte are the start address; bit 7 = 1 makes the transfer a read (bytes shifted in after the command are then ignored), bit 7 = 0 a write.
- R3: In a write, each byte after the command goes to the current address and the address then steps by one, so a 16-bit write stores its first data byte at the even address (high half) and the second at the next one (low half).
- R4: In a read, each byte after the command returns the register at the current address and the address then steps by one; a 4-byte read from 0x3A returns the ground-open word then the supply-open word, each high byte first.
- R5: Register map: 0x02 control (bit 0 test enable, bit 1 soft reset, other bits read 0), 0x04 sensing mode (bit n sets mode of bank n, 1 = supply-open, unused bits read 0), 0x1E test data, 0x3A/0x3B ground-open word high/low, 0x3C/0x3D supply-open word high/low; the stored values drive test_en, sense_mode, gnd_thr and sup_thr.
- R6: Status reads: 0x10, 0x12, 0x14, 0x16 return channels 7:0, 15:8, 23:16, 31:24; 0x78 to 0x7B return channels 31:24, 23:16, 15:8, 7:0.
- R7: The channel word is captured when the command byte completes; all status bytes of one transfer come from that capture.
- R8: While test enable is set, every status byte returns the test data register instead of the channel inputs.
- R9: Writing control with bit 1 = 1 clears every register, including test enable; while bit 1 stays set, writes to other addresses are ignored; writing control with bit 1 = 0 releases it, and bit 0 of that write applies.
- R10: Reads of unmapped addresses return 0x00; writes to unmapped or status addresses change nothing.
- R11: rst_n low clears all registers to zero at once, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| chan_in | input | 8*NUM_BANKS | Comparator result per channel |
| test_en | output | 1 | Test enable bit of control |
| sense_mode | output | NUM_BANKS | Sensing mode per bank, 1 = supply-open |
| gnd_thr | output | 16 | Ground-open threshold/hysteresis word |
| sup_thr | output | 16 | Supply-open threshold/hysteresis word |

## Verification
A wrong address pointer shows up on the very next byte of a burst, as a value from the wrong register, or as a write landing beside its target and changing a configuration port. A bit counter that is off by one shifts or misframes whole bytes and appears on the first read-back. Snapshot or soft-reset state errors show only across a sequence: a channel change part-way through a burst, or a write made while reset is held and read back after release. The directed scenarios are built around those sequences.

// File: rtl/dsi_pkg.sv
`timescale 1ns/1ps
package dsi_pkg;
   localparam int ADDR_W = 7;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t A_CTRL   = 7'h02;
   localparam addr_t A_SENSE  = 7'h04;
   localparam addr_t A_STAT0  = 7'h10;
   localparam addr_t A_TDATA  = 7'h1E;
   localparam addr_t A_GTHR_H = 7'h3A;
   localparam addr_t A_GTHR_L = 7'h3B;
   localparam addr_t A_STHR_H = 7'h3C;
   localparam addr_t A_STHR_L = 7'h3D;
   localparam addr_t A_BURST  = 7'h78;

   localparam int BURST_BYTES = 4;

   typedef struct packed {
      logic srst;
      logic test;
   } ctrl_t;

   function automatic logic wr_mapped(input addr_t a);
      return (a == A_CTRL) || (a == A_SENSE) || (a == A_TDATA) ||
             (a == A_GTHR_H) || (a == A_GTHR_L) ||
             (a == A_STHR_H) || (a == A_STHR_L);
   endfunction
endpackage

// File: rtl/dsi_sync.sv
`timescale 1ns/1ps
module dsi_sync #(
   parameter int               W       = 3,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dsi_shifter.sv
`timescale 1ns/1ps
module dsi_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_s,
   input  logic       sclk_s,
   input  logic       mosi_s,
   input  logic [7:0] tx_byte,
   output logic       byte_done,
   output logic       is_cmd,
   output logic [7:0] rx_byte,
   output logic       load,
   output logic       miso
);
   logic       sclk_d;
   logic [2:0] bit_cnt;
   logic [6:0] rx_q;
   logic [7:0] tx_q;
   logic       first_q;
   logic       rise, fall;

   assign rise      = sclk_s & ~sclk_d;
   assign fall      = ~sclk_s & sclk_d;
   assign byte_done = ~cs_s & rise & (bit_cnt == 3'd7);
   assign load      = ~cs_s & fall & (bit_cnt == 3'd0);
   assign rx_byte   = {rx_q, mosi_s};
   assign is_cmd    = first_q;
   assign miso      = tx_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         first_q <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         if (cs_s) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            first_q <= 1'b1;
         end else begin
            if (rise) begin
               rx_q    <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) first_q <= 1'b0;
            end
            if (fall) tx_q <= (bit_cnt == 3'd0) ? tx_byte : {tx_q[6:0], 1'b0};
         end
      end
   end

   // R1: miso rests low once the select has been high for a cycle
   a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !miso);
endmodule

// File: rtl/dsi_regs.sv
`timescale 1ns/1ps
module dsi_regs
   import dsi_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int NUM_CH   = 8 * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_done,
   input  logic              is_cmd,
   input  logic [7:0]        rx_byte,
   input  logic              load,
   input  logic [NUM_CH-1:0] chan_in,
   output logic [7:0]        tx_byte,
   output logic              test_en,
   output logic [NUM_BANKS-1:0] sense_mode,
   output logic [15:0]       gnd_thr,
   output logic [15:0]       sup_thr
);
   addr_t                ptr;
   logic                 rd_mode;
   ctrl_t                ctrl_q;
   logic [NUM_BANKS-1:0] sense_q;
   logic [7:0]           tdata_q;
   logic [15:0]          gthr_q, sthr_q;
   logic [NUM_CH-1:0]    snap_q;
   logic [NUM_CH-1:0]    stat_eff;
   logic                 wr;

   assign stat_eff = ctrl_q.test ? {NUM_BANKS{tdata_q}} : chan_in;
   assign wr       = byte_done & ~is_cmd & ~rd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         rd_mode <= 1'b0;
         ctrl_q  <= '0;
         sense_q <= '0;
         tdata_q <= '0;
         gthr_q  <= '0;
         sthr_q  <= '0;
         snap_q  <= '0;
      end else begin
         if (byte_done && is_cmd) begin
            ptr     <= rx_byte[6:0];
            rd_mode <= rx_byte[7];
            snap_q  <= stat_eff;
         end else if (wr || (load && rd_mode)) begin
            ptr <= ptr + 7'd1;
         end
         if (wr) begin
            if (ptr == A_CTRL) begin
               ctrl_q.srst <= rx_byte[1];
               ctrl_q.test <= rx_byte[0] & ~rx_byte[1];
            end else if (!ctrl_q.srst) begin
               case (ptr)
                  A_SENSE:  sense_q      <= rx_byte[NUM_BANKS-1:0];
                  A_TDATA:  tdata_q      <= rx_byte;
                  A_GTHR_H: gthr_q[15:8] <= rx_byte;
                  A_GTHR_L: gthr_q[7:0]  <= rx_byte;
                  A_STHR_H: sthr_q[15:8] <= rx_byte;
                  A_STHR_L: sthr_q[7:0]  <= rx_byte;
                  default: ;
               endcase
            end
         end
         if (ctrl_q.srst) begin
            sense_q <= '0;
            tdata_q <= '0;
            gthr_q  <= '0;
            sthr_q  <= '0;
         end
      end
   end

   always_comb begin
      tx_byte = 8'h00;
      case (ptr)
         A_CTRL:   tx_byte = {6'b0, ctrl_q.srst, ctrl_q.test};
         A_SENSE:  tx_byte = 8'(sense_q);
         A_TDATA:  tx_byte = tdata_q;
         A_GTHR_H: tx_byte = gthr_q[15:8];
         A_GTHR_L: tx_byte = gthr_q[7:0];
         A_STHR_H: tx_byte = sthr_q[15:8];
         A_STHR_L: tx_byte = sthr_q[7:0];
         default:  tx_byte = 8'h00;
      endcase
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (ptr == A_STAT0 + 7'(2 * b))
            tx_byte = snap_q[8*b +: 8];
         if (ptr == A_BURST + 7'(BURST_BYTES - 1 - b))
            tx_byte = snap_q[8*b +: 8];
      end
   end

   assign test_en    = ctrl_q.test;
   assign sense_mode = sense_q;
   assign gnd_thr    = gthr_q;
   assign sup_thr    = sthr_q;

   // R10: a write to an address outside the writable set leaves all storage alone
   a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_mapped(ptr)) |=> $stable({ctrl_q, sense_q, tdata_q, gthr_q, sthr_q}));

   // R9: one cycle into soft reset every configuration register reads zero
   a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.srst |=> (sense_q == '0 && tdata_q == '0 && gthr_q == '0 && sthr_q == '0));

   // R9: test enable cannot be set while soft reset is held
   a_r9_srst_no_test: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.srst |-> !ctrl_q.test);

   // R7: the captured channel word holds for the rest of a transfer
   a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_cmd && $past(!is_cmd)) |-> $stable(snap_q));
endmodule

// File: rtl/dsi_spi_slave.sv
`timescale 1ns/1ps
module dsi_spi_slave #(
   parameter int  NUM_BANKS   = 4,
   parameter int  SYNC_STAGES = 2,
   localparam int NUM_CH      = 8 * NUM_BANKS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 sclk,
   input  logic                 mosi,
   output logic                 miso,
   input  logic [NUM_CH-1:0]    chan_in,
   output logic                 test_en,
   output logic [NUM_BANKS-1:0] sense_mode,
   output logic [15:0]          gnd_thr,
   output logic [15:0]          sup_thr
);
   initial begin
      assert (NUM_BANKS >= 1 && NUM_BANKS <= 4)
         else $error("NUM_BANKS must lie in 1..4");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0] pins_s;
   logic       byte_done, is_cmd, load;
   logic [7:0] rx_byte, tx_byte;

   dsi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({cs_n, sclk, mosi}),
      .q    (pins_s)
   );

   dsi_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (pins_s[2]),
      .sclk_s   (pins_s[1]),
      .mosi_s   (pins_s[0]),
      .tx_byte  (tx_byte),
      .byte_done(byte_done),
      .is_cmd   (is_cmd),
      .rx_byte  (rx_byte),
      .load     (load),
      .miso     (miso)
   );

   dsi_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_done (byte_done),
      .is_cmd    (is_cmd),
      .rx_byte   (rx_byte),
      .load      (load),
      .chan_in   (chan_in),
      .tx_byte   (tx_byte),
      .test_en   (test_en),
      .sense_mode(sense_mode),
      .gnd_thr   (gnd_thr),
      .sup_thr   (sup_thr)
   );
endmodule

// File: tb/dsi_spi_slave_tb.sv
`timescale 1ns/1ps
module dsi_spi_slave_tb_top;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        mosi = 1'b0;
   logic        miso;
   logic [31:0] chan_in = 32'h0;
   logic        test_en;
   logic [3:0]  sense_mode;
   logic [15:0] gnd_thr, sup_thr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dsi_spi_slave dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .miso(miso), .chan_in(chan_in), .test_en(test_en),
      .sense_mode(sense_mode), .gnd_thr(gnd_thr), .sup_thr(sup_thr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input int nbytes, input logic [63:0] t, output logic [63:0] r);
      r = '0;
      cs_n = 1'b0;
      idle(HALF);
      for (int i = 0; i < nbytes * 8; i++) begin
         mosi = t[63-i];
         idle(HALF);
         r[63-i] = miso;
         sclk = 1'b1;
         idle(HALF);
         sclk = 1'b0;
      end
      idle(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      idle(2 * HALF);
   endtask

   task automatic wr8(input logic [6:0] a, input logic [7:0] d);
      logic [63:0] r;
      xfer(2, {1'b0, a, d, 48'h0}, r);
   endtask

   task automatic wr16(input logic [6:0] a, input logic [15:0] d);
      logic [63:0] r;
      xfer(3, {1'b0, a, d, 40'h0}, r);
   endtask

   task automatic rd(input logic [6:0] a, input int n, output logic [31:0] v);
      logic [63:0] r;
      xfer(1 + n, {1'b1, a, 56'h0}, r);
      v = r[55:24] >> (8 * (4 - n));
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R11 reset test_en", 32'(test_en), 32'h0);
      chk("R11 reset sense_mode", 32'(sense_mode), 32'h0);
      chk("R11 reset gnd_thr", 32'(gnd_thr), 32'h0);
      chk("R11 reset sup_thr", 32'(sup_thr), 32'h0);
      chk("R1 miso idle", 32'(miso), 32'h0);
      rd(7'h02, 1, v);
      chk("R11 reset ctrl readback", v, 32'h0);
   endtask

   task automatic t_byte_write;
      logic [31:0] v;
      wr8(7'h04, 8'h0A);
      chk("R3 sense_mode after write", 32'(sense_mode), 32'hA);
      rd(7'h04, 1, v);
      chk("R5 sense readback", v, 32'h0A);
      wr8(7'h04, 8'hFF);
      rd(7'h04, 1, v);
      chk("R5 sense unused bits read 0", v, 32'h0F);
      wr8(7'h1E, 8'hC3);
      rd(7'h1E, 1, v);
      chk("R5 test data readback", v, 32'hC3);
   endtask

   task automatic t_word_write;
      logic [31:0] v;
      wr16(7'h3A, 16'h0206);
      chk("R3 gnd_thr word write", 32'(gnd_thr), 32'h0206);
      wr16(7'h3C, 16'h1234);
      chk("R3 sup_thr word write", 32'(sup_thr), 32'h1234);
      rd(7'h3A, 2, v);
      chk("R4 16-bit read big-endian", v, 32'h0206);
      rd(7'h3D, 1, v);
      chk("R3 low half at odd address", v, 32'h34);
      rd(7'h3A, 4, v);
      chk("R4 4-byte read across both words", v, 32'h02061234);
   endtask

   task automatic t_direction;
      logic [63:0] r;
      xfer(2, {8'h84, 8'hFF, 48'h0}, r);
      chk("R2 read ignores shifted-in data", 32'(sense_mode), 32'hF);
      chk("R2 read returns addressed register", 32'(r[55:48]), 32'h0F);
   endtask

   task automatic t_abort;
      logic [31:0] v;
      cs_n = 1'b0;
      idle(HALF);
      for (int i = 0; i < 5; i++) begin
         mosi = (i == 4);
         idle(HALF);
         sclk = 1'b1;
         idle(HALF);
         sclk = 1'b0;
      end
      idle(HALF);
      cs_n = 1'b1;
      mosi = 1'b0;
      idle(2 * HALF);
      wr8(7'h04, 8'h03);
      rd(7'h04, 1, v);
      chk("R1 transfer after aborted byte", v, 32'h03);
      rd(7'h02, 1, v);
      chk("R1 aborted byte wrote nothing", v, 32'h00);
   endtask

   task automatic t_status;
      logic [31:0] v;
      chan_in = 32'hA1B2C3D4;
      rd(7'h10, 1, v); chk("R6 bank 0 byte", v, 32'hD4);
      rd(7'h12, 1, v); chk("R6 bank 1 byte", v, 32'hC3);
      rd(7'h14, 1, v); chk("R6 bank 2 byte", v, 32'hB2);
      rd(7'h16, 1, v); chk("R6 bank 3 byte", v, 32'hA1);
      rd(7'h78, 4, v); chk("R6 burst read", v, 32'hA1B2C3D4);
      rd(7'h7B, 1, v); chk("R6 burst last byte", v, 32'hD4);
   endtask

   task automatic t_snapshot;
      logic [63:0] r;
      chan_in = 32'h11223344;
      fork
         xfer(5, {8'hF8, 56'h0}, r);
         begin
            idle(200);
            chan_in = 32'hEEDDCCBB;
         end
      join
      chk("R7 burst uses captured word", r[55:24], 32'h11223344);
      xfer(5, {8'hF8, 56'h0}, r);
      chk("R7 next transfer sees new word", r[55:24], 32'hEEDDCCBB);
   endtask

   task automatic t_test_mode;
      logic [31:0] v;
      wr8(7'h1E, 8'h5A);
      wr8(7'h02, 8'h01);
      chk("R5 test_en output", 32'(test_en), 32'h1);
      rd(7'h78, 4, v);
      chk("R8 burst returns test data", v, 32'h5A5A5A5A);
      rd(7'h12, 1, v);
      chk("R8 bank byte returns test data", v, 32'h5A);
      wr8(7'h02, 8'h00);
      rd(7'h10, 1, v);
      chk("R8 live inputs after test off", v, 32'hBB);
   endtask

   task automatic t_soft_reset;
      logic [31:0] v;
      wr16(7'h3A, 16'h0408);
      wr8(7'h02, 8'h01);
      wr8(7'h02, 8'h03);
      chk("R9 srst clears gnd_thr", 32'(gnd_thr), 32'h0);
      chk("R9 srst clears sup_thr", 32'(sup_thr), 32'h0);
      chk("R9 srst clears sense", 32'(sense_mode), 32'h0);
      chk("R9 srst clears test_en", 32'(test_en), 32'h0);
      rd(7'h02, 1, v);
      chk("R9 ctrl reads reset bit", v, 32'h02);
      wr8(7'h04, 8'h0F);
      chk("R9 write ignored in reset", 32'(sense_mode), 32'h0);
      wr8(7'h02, 8'h01);
      chk("R9 release applies bit 0", 32'(test_en), 32'h1);
      rd(7'h04, 1, v);
      chk("R9 sense still clear after release", v, 32'h00);
      wr8(7'h04, 8'h05);
      chk("R9 writes accepted after release", 32'(sense_mode), 32'h5);
      wr8(7'h02, 8'h00);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr16(7'h3C, 16'h0A0C);
      rd(7'h05, 1, v); chk("R10 unmapped read 0x05", v, 32'h00);
      rd(7'h20, 1, v); chk("R10 unmapped read 0x20", v, 32'h00);
      wr8(7'h06, 8'hFF);
      wr8(7'h10, 8'hFF);
      chk("R10 unmapped write sense", 32'(sense_mode), 32'h5);
      chk("R10 unmapped write sup_thr", 32'(sup_thr), 32'h0A0C);
      chk("R10 unmapped write test_en", 32'(test_en), 32'h0);
      rd(7'h10, 1, v);
      chk("R10 status write ignored", v, 32'hBB);
   endtask

   task automatic t_hw_reset;
      wr16(7'h3A, 16'h0606);
      wr8(7'h02, 8'h01);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk("R11 async clear gnd_thr", 32'(gnd_thr), 32'h0);
      chk("R11 async clear test_en", 32'(test_en), 32'h0);
      chk("R11 async clear sense", 32'(sense_mode), 32'h0);
      idle(3);
      rst_n = 1'b1;
      idle(4);
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_byte_write();
      t_word_write();
      t_direction();
      t_abort();
      t_status();
      t_snapshot();
      t_test_mode();
      t_soft_reset();
      t_unmapped();
      t_hw_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule